// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous framed bit stream suited to a full-duplex differential line driver. A character is offered on a valid/ready handshake together with its frame format: the number of data bits, the parity mode and the length of the stop interval. Once the character is accepted, the block sends a low start bit, then the data bits with the least significant bit first, then an optional parity bit, and then a high stop interval. When no character is in flight, the line rests high.

All timing comes from an external enable that pulses at sixteen times the bit rate. One bit lasts sixteen of these pulses, so a half bit is eight pulses. This is how the 1.5 stop-bit option is timed. The format is captured when a character is accepted, so the format inputs may change while a frame is being sent. The baud-rate generator, the line driver and any modem control signals are outside the block.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txd_o` is 1, `tx_ready_o` is 1 and `busy_o` is 0.
- R2: Every frame opens with exactly one start bit at 0, lasting 16 ticks, beginning in the cycle after acceptance.
- R3: `len_sel_i` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are sent least significant bit first. Input bits above the selected length have no effect on the line, including on the parity bit.
- R4: `par_mode_i` encoding: 0 none, 1 even, 2 odd, 3 stick. With any mode other than none, one parity bit is sent after the last data bit and before the stop interval. With none, no parity bit is sent.
- R5: In even mode, the parity bit makes the number of 1s across the data bits and the parity bit even. In odd mode, it makes that number odd.
- R6: In stick mode, the parity bit equals `stick_val_i` as sampled at acceptance.
- R7: `stop_sel_i` encoding: 0 gives 1 stop bit (16 ticks), 1 gives 1.5 (24 ticks), 2 or 3 give 2 (32 ticks). The line is 1 for the whole stop interval.
- R8: Bit timing advances only in cycles where `tick_i` is 1. Each start, data and parity bit lasts 16 ticks. A tick in the acceptance cycle is not counted.
- R9: Data and all format inputs are sampled in the cycle where `tx_valid_i` and `tx_ready_o` are both 1. Later changes to them have no effect on the frame in flight.
- R10: A character is accepted when `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` stays 0 (and `busy_o` 1) from the next cycle until the final stop tick has been counted, and is 1 in the cycle after that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Enable at sixteen times the bit rate |
| tx_valid_i | input | 1 | A character is offered |
| tx_ready_o | output | 1 | Block can accept a character |
| tx_data_i | input | 8 | Character to send |
| len_sel_i | input | 2 | Data length code (5..8 bits) |
| par_mode_i | input | 2 | Parity mode code |
| stick_val_i | input | 1 | Parity value used in stick mode |
| stop_sel_i | input | 2 | Stop interval code |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |

## Verification
Two events can land in the same clock edge: acceptance of a character and a baud tick. The bench holds `tick_i` high in every acceptance cycle, then checks the line tick by tick to confirm that the start bit still lasts a full 16 ticks. Two other events can also coincide: the final stop tick and a new offer with valid held high. The bench starts the next frame in the very cycle where ready returns, and checks that the frames abut with no idle gap. It also checks that the format inputs, which are scrambled right after acceptance, do not leak into the frame in flight.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_STICK = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    STOP_ONE     = 2'b00,
    STOP_ONEHALF = 2'b01,
    STOP_TWO     = 2'b10,
    STOP_TWO_ALT = 2'b11
  } stop_sel_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic [1:0] len_code;
    par_mode_e  par;
    logic       stick;
    stop_sel_e  stop;
  } frame_cfg_t;

endpackage

// File: rtl/sftx_parity_gen.sv
module sftx_parity_gen
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        len_code_i,
  input  par_mode_e         mode_i,
  input  logic              stick_i,
  output logic              par_bit_o
);

  localparam int MIN_LEN = DATA_W - 3;

  logic [DATA_W-1:0] keep_mask;
  logic              ones_odd;

  // Mask out the bits above the selected character length.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign keep_mask[i] = (i < (MIN_LEN + int'(len_code_i)));
    end
  endgenerate

  assign ones_odd = ^(data_i & keep_mask);

  always_comb begin
    unique case (mode_i)
      PAR_EVEN:  par_bit_o = ones_odd;
      PAR_ODD:   par_bit_o = ~ones_odd;
      PAR_STICK: par_bit_o = stick_i;
      default:   par_bit_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
  parameter  int OSR = 16,
  localparam int CW  = $clog2(2 * OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] last_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = tick_i && !clr_i && (cnt_q == last_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (done_o)  cnt_d = '0;
    else if (tick_i)  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The count only moves on a tick or a clear.
  assert_cnt_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !clr_i |=> $stable(cnt_q));

  assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> cnt_q <= last_i);

endmodule

// File: rtl/sftx_frame_seq.sv
module sftx_frame_seq
  import sftx_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int OSR    = 16,
  localparam int CW     = $clog2(2 * OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  frame_cfg_t        cfg_i,
  input  logic              par_bit_i,
  input  logic              tmr_done_i,
  output logic              tmr_clr_o,
  output logic [CW-1:0]     tmr_last_o,
  output logic              ready_o,
  output logic              busy_o,
  output logic              txd_o
);

  localparam int MIN_LEN = DATA_W - 3;
  localparam int BCW     = $clog2(DATA_W + 1);

  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [BCW-1:0]    left_q,  left_d;
  logic              par_q,   par_d;
  frame_cfg_t        cfg_q,   cfg_d;
  logic              accept;

  assign ready_o   = (phase_q == PH_IDLE);
  assign busy_o    = !ready_o;
  assign accept    = valid_i && ready_o;
  assign tmr_clr_o = (phase_q == PH_IDLE);

  // Tick limit for the current bit period.
  always_comb begin
    tmr_last_o = CW'(OSR - 1);
    if (phase_q == PH_STOP) begin
      unique case (cfg_q.stop)
        STOP_ONE:     tmr_last_o = CW'(OSR - 1);
        STOP_ONEHALF: tmr_last_o = CW'(OSR + OSR / 2 - 1);
        default:      tmr_last_o = CW'(2 * OSR - 1);
      endcase
    end
  end

  // Next-state logic.
  always_comb begin
    phase_d = phase_q;
    shreg_d = shreg_q;
    left_d  = left_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_START;
          shreg_d = data_i;
          cfg_d   = cfg_i;
          par_d   = par_bit_i;
          left_d  = BCW'(MIN_LEN) + BCW'(cfg_i.len_code);
        end
      end
      PH_START: begin
        if (tmr_done_i) phase_d = PH_DATA;
      end
      PH_DATA: begin
        if (tmr_done_i) begin
          shreg_d = shreg_q >> 1;
          left_d  = left_q - BCW'(1);
          if (left_q == BCW'(1))
            phase_d = (cfg_q.par == PAR_NONE) ? PH_STOP : PH_PARITY;
        end
      end
      PH_PARITY: begin
        if (tmr_done_i) phase_d = PH_STOP;
      end
      PH_STOP: begin
        if (tmr_done_i) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      par_q   <= 1'b1;
      cfg_q   <= '0;
    end else begin
      phase_q <= phase_d;
      shreg_q <= shreg_d;
      left_q  <= left_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
    end
  end

  // Line level per phase.
  always_comb begin
    unique case (phase_q)
      PH_START:  txd_o = 1'b0;
      PH_DATA:   txd_o = shreg_q[0];
      PH_PARITY: txd_o = par_q;
      default:   txd_o = 1'b1;
    endcase
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> txd_o);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !txd_o);

  assert_data_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DATA |-> left_q != '0);

  assert_parity_only_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_PARITY |-> cfg_q.par != PAR_NONE);

  assert_stop_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_STOP |-> txd_o);

  assert_phase_waits_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !tick_i |=> $stable(phase_q) && $stable(shreg_q));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(cfg_q) && $stable(par_q));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready_o);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_mode_i,
  input  logic              stick_val_i,
  input  logic [1:0]        stop_sel_i,
  output logic              txd_o,
  output logic              busy_o
);

  localparam int CW = $clog2(2 * OSR);

  frame_cfg_t    cfg_in;
  logic          par_bit;
  logic          tmr_clr;
  logic          tmr_done;
  logic [CW-1:0] tmr_last;

  assign cfg_in.len_code = len_sel_i;
  assign cfg_in.par      = par_mode_e'(par_mode_i);
  assign cfg_in.stick    = stick_val_i;
  assign cfg_in.stop     = stop_sel_e'(stop_sel_i);

  sftx_parity_gen #(.DATA_W(DATA_W)) u_par (
    .data_i     (tx_data_i),
    .len_code_i (len_sel_i),
    .mode_i     (cfg_in.par),
    .stick_i    (stick_val_i),
    .par_bit_o  (par_bit)
  );

  sftx_bit_timer #(.OSR(OSR)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .tick_i (tick_i),
    .last_i (tmr_last),
    .done_o (tmr_done)
  );

  sftx_frame_seq #(.DATA_W(DATA_W), .OSR(OSR)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .valid_i    (tx_valid_i),
    .data_i     (tx_data_i),
    .cfg_i      (cfg_in),
    .par_bit_i  (par_bit),
    .tmr_done_i (tmr_done),
    .tmr_clr_o  (tmr_clr),
    .tmr_last_o (tmr_last),
    .ready_o    (tx_ready_o),
    .busy_o     (busy_o),
    .txd_o      (txd_o)
  );

endmodule

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;
  logic [7:0] tx_data_i = 8'h00;
  logic [1:0] len_sel_i = 2'd3;
  logic [1:0] par_mode_i = 2'd0;
  logic       stick_val_i = 1'b0;
  logic [1:0] stop_sel_i = 2'd0;
  logic       txd_o;
  logic       busy_o;

  int vec_cnt  = 0;
  int miss_cnt = 0;
  int tick_per = 1;
  int tick_ph  = 0;

  always #10 clk = ~clk;

  serial_frame_tx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .tx_data_i   (tx_data_i),
    .len_sel_i   (len_sel_i),
    .par_mode_i  (par_mode_i),
    .stick_val_i (stick_val_i),
    .stop_sel_i  (stop_sel_i),
    .txd_o       (txd_o),
    .busy_o      (busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      miss_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive tick for the coming edge; returns whether a tick was driven.
  task automatic drive_tick(output bit t);
    tick_ph++;
    t = ((tick_ph % tick_per) == 0);
    tick_i = t;
  endtask

  // Send one frame starting at a negedge with the block idle, check it tick by tick.
  task automatic run_frame(input logic [7:0] d, input int lc, input int pm, input bit sv,
                           input int ss, input string req);
    int  nb, pe, stopt, total, t, idx, exp_b, bad_t, bad_a, bad_e, tbad;
    bit  pb, tk, ones;
    nb = 5 + lc;
    pe = (pm != 0);
    ones = 1'b0;
    for (int i = 0; i < nb; i++) ones ^= d[i];
    pb = (pm == 1) ? ones : (pm == 2) ? !ones : sv;
    stopt = (ss == 0) ? 16 : (ss == 1) ? 24 : 32;
    total = 16 * (1 + nb + pe) + stopt;
    tx_data_i = d; len_sel_i = 2'(lc); par_mode_i = 2'(pm);
    stick_val_i = sv; stop_sel_i = 2'(ss);
    tx_valid_i = 1'b1;
    tick_i = 1'b1;                     // tick in the acceptance cycle: must not count (R8)
    @(posedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
    tx_data_i = ~d; len_sel_i = ~len_sel_i; par_mode_i = ~par_mode_i;
    stick_val_i = ~sv; stop_sel_i = stop_sel_i ^ 2'd1;   // scramble after acceptance (R9)
    t = 0; bad_t = -1; bad_a = 0; bad_e = 0; tbad = -1;
    for (int g = 0; g < 4000; g++) begin
      idx = t / 16;
      if (idx == 0)              exp_b = 0;
      else if (idx <= nb)        exp_b = d[idx-1];
      else if (pe && idx == nb+1) exp_b = pb;
      else                        exp_b = 1;
      if (t < total && txd_o !== exp_b[0] && bad_t < 0) begin
        bad_t = t; bad_a = txd_o; bad_e = exp_b;
      end
      if (tbad < 0 && (tx_ready_o !== (t >= total) || busy_o !== (t < total))) tbad = t;
      if (t >= total) break;
      drive_tick(tk);
      if (tk) t++;
      @(negedge clk);
    end
    check(bad_t < 0, $sformatf("%s line at tick %0d", req, bad_t), bad_a, bad_e);
    check(tbad < 0, $sformatf("R10 R8 %s ready/busy at tick (exp ready at %0d)", req, total),
          tbad, total);
  endtask

  task automatic t_reset;
    check(txd_o === 1'b1, "R1 reset txd", txd_o, 1);
    check(tx_ready_o === 1'b1, "R1 reset ready", tx_ready_o, 1);
    check(busy_o === 1'b0, "R1 reset busy", busy_o, 0);
  endtask

  task automatic t_idle_hold;
    bit tk;
    bit held = 1'b1;
    for (int i = 0; i < 40; i++) begin
      drive_tick(tk);
      @(negedge clk);
      if (txd_o !== 1'b1 || tx_ready_o !== 1'b1) held = 1'b0;
    end
    check(held, "R1 idle line stays mark", held, 1);
  endtask

  task automatic t_basic;
    run_frame(8'hA5, 3, 0, 0, 0, "R2 R3 8N1 A5");
    run_frame(8'h3C, 3, 0, 0, 0, "R2 R3 8N1 3C");
  endtask

  task automatic t_lengths;
    run_frame(8'hE3, 0, 1, 0, 0, "R3 R5 5-bit upper bits ignored");
    run_frame(8'hD6, 1, 0, 0, 0, "R3 6-bit");
    run_frame(8'hFF, 2, 2, 0, 0, "R3 R5 7-bit odd");
  endtask

  task automatic t_parity;
    run_frame(8'h07, 3, 1, 0, 0, "R4 R5 even, odd ones");
    run_frame(8'h0F, 3, 1, 0, 0, "R4 R5 even, even ones");
    run_frame(8'h07, 3, 2, 0, 0, "R4 R5 odd, odd ones");
    run_frame(8'h00, 3, 2, 0, 0, "R4 R5 odd, zero");
    run_frame(8'h55, 3, 3, 1, 0, "R6 stick one");
    run_frame(8'hFF, 3, 3, 0, 0, "R6 stick zero");
  endtask

  task automatic t_stops;
    run_frame(8'h81, 3, 0, 0, 1, "R7 1.5 stop");
    run_frame(8'h81, 3, 1, 0, 2, "R7 2 stop");
    run_frame(8'h42, 0, 2, 0, 3, "R7 2 stop alt code");
  endtask

  task automatic t_tick_gaps;
    tick_per = 3;
    run_frame(8'h96, 3, 1, 0, 1, "R8 sparse ticks");
    tick_per = 5;
    run_frame(8'h2B, 1, 3, 1, 2, "R8 sparser ticks");
    tick_per = 1;
  endtask

  task automatic t_cfg_sampled;
    run_frame(8'hC9, 2, 2, 1, 0, "R9 inputs scrambled in flight");
  endtask

  task automatic t_back_to_back;
    // run_frame leaves us at the negedge where ready returned; start next at once.
    run_frame(8'h11, 3, 0, 0, 0, "R10 first of pair");
    run_frame(8'hEE, 3, 1, 0, 1, "R10 second, no gap");
    run_frame(8'h5A, 0, 3, 0, 2, "R10 third, no gap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_hold();
    t_basic();
    t_lengths();
    t_parity();
    t_stops();
    t_tick_gaps();
    t_cfg_sampled();
    t_back_to_back();
    t_idle_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    #4000000;
    miss_cnt++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule